// File: doc/BRIEF.md
# Millisecond Interval Interrupt Timer

This block turns a programmed period into a repeating interrupt request. Software writes a period whose scale matches the low word of a free-running time base: the lowest 12 bits are sub-millisecond units, and each step of bit 12 is one millisecond. The block keeps that value for read-back. It also keeps a separate signed time-to-go count, which is loaded with the period rounded up to whole milliseconds. An external strobe marks each overflow of the millisecond counter. The time-to-go count drops by one millisecond on each such strobe. When the count reaches zero or goes below it, a sticky done flag is raised and the count reloads, so the interrupt repeats.

The countdown follows a small state machine. `CNT_IDLE` is the state after reset, and in it strobes are ignored. The transition `ARM` moves to `CNT_RUN` on the first accepted period write. In `CNT_RUN`, the transition `RELOAD` follows an expiry, `RESTART` follows a new write, and `STEP` follows a plain strobe. The flag has its own machine. It moves from `FLAG_LOW` to `FLAG_HIGH` on the transition `RAISE` (an expiry), and back on `DROP` (a clear request with no expiry in the same cycle). The done flag drives the interrupt request. It also appears at bit 30 of a 36-bit status word.

Top module: `ms_interval_timer`

## Requirements
- R1: `per_rdata` returns exactly the 36-bit value of the last accepted period write, from the cycle after that write; it is 0 after reset.
- R2: An accepted period P arms a countdown of N = floor(P/4096) + (1 if P mod 4096 is nonzero) milliseconds. `done_flag` rises after the clock edge of the N-th `ms_tick` that follows the write.
- R3: A write of 0, which rounds to zero milliseconds, is ignored. The read-back period, the countdown in progress and the flag state are all unchanged.
- R4: The first decrement happens at the first `ms_tick` after the write edge, whatever the phase of the strobe. A period of 1 to 4096 therefore expires on the very next strobe.
- R5: `done_flag` rises only on an edge where `ms_tick` is high. Before any accepted write, strobes have no effect.
- R6: `done_flag` stays high until `done_clr`. If `done_clr` and an expiry fall in the same cycle, the flag stays high.
- R7: After an expiry, the countdown reloads the rounded period, so expiries repeat every N strobes.
- R8: `irq` equals `done_flag`. `status_word` carries `done_flag` at bit 30, and all its other bits are 0.
- R9: A period write in the same cycle as `ms_tick` restarts the countdown from the new value, and that strobe does not decrement it. A write during a countdown discards the old remaining time.
- R10: After reset, `done_flag`, `irq`, `status_word` and `per_rdata` are all 0, and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle strobe on each millisecond counter overflow |
| per_wr_en | input | 1 | Period write request |
| per_wr_data | input | 36 | Period value to write |
| done_clr | input | 1 | Request to clear the done flag |
| per_rdata | output | 36 | Read-back of the last accepted period |
| done_flag | output | 1 | Sticky interval-done flag |
| irq | output | 1 | Interrupt request |
| status_word | output | 36 | Status word with done at bit 30 |

## Verification
Every result in this block is due one clock edge after the stimulus that causes it. A write shows on `per_rdata`, a strobe that expires the countdown raises `done_flag`, and a clear drops it, each after that single register stage. The bench drives a cycle's inputs on the falling edge and applies them at the next rising edge. It then updates its millisecond-count model and compares all four outputs on the following falling edge. This puts every check half a period after the only edge that can change the outputs. Strobe spacing, write phase and clear timing are randomised, so expiries land both with and without a coinciding clear or write.

// File: rtl/ms_timer_pkg.sv
package ms_timer_pkg;

    // Countdown controller states
    typedef enum logic {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_t;

    // Done flag states
    typedef enum logic {
        FLAG_LOW  = 1'b0,
        FLAG_HIGH = 1'b1
    } flag_state_t;

endpackage

// File: rtl/period_round.sv
module period_round #(
    parameter int WORD_W = 36,
    parameter int SUB_W  = 12
) (
    input  logic [WORD_W-1:0] raw,
    output logic [WORD_W:0]   rounded,
    output logic              is_zero
);
    localparam logic [WORD_W:0] STEP = {{WORD_W{1'b0}}, 1'b1} << SUB_W;

    logic [WORD_W:0] trunc;
    logic            frac_nz;

    always_comb begin
        trunc   = {1'b0, raw[WORD_W-1:SUB_W], {SUB_W{1'b0}}};
        frac_nz = |raw[SUB_W-1:0];
        rounded = trunc + (frac_nz ? STEP : '0);
        is_zero = (raw == '0);
    end
endmodule

// File: rtl/ttg_counter.sv
module ttg_counter
    import ms_timer_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int SUB_W  = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WORD_W:0] load_val,
    input  logic            tick,
    output logic            expire
);
    localparam int TTG_W = WORD_W + 2;
    localparam logic signed [TTG_W-1:0] STEP_S = {{(TTG_W-1){1'b0}}, 1'b1} << SUB_W;

    cnt_state_t               state_q, state_d;
    logic signed [TTG_W-1:0]  ttg_q, ttg_d, ttg_dec;
    logic [WORD_W:0]          reload_q, reload_d;
    logic                     reached;

    assign ttg_dec = ttg_q - STEP_S;
    assign reached = ttg_dec[TTG_W-1] || (ttg_dec == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CNT_IDLE;
            ttg_q    <= '0;
            reload_q <= '0;
        end else begin
            state_q  <= state_d;
            ttg_q    <= ttg_d;
            reload_q <= reload_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        ttg_d    = ttg_q;
        reload_d = reload_q;
        expire   = 1'b0;
        unique case (state_q)
            CNT_IDLE: begin
                if (load) begin                       // ARM
                    state_d  = CNT_RUN;
                    ttg_d    = $signed({1'b0, load_val});
                    reload_d = load_val;
                end
            end
            CNT_RUN: begin
                if (load) begin                       // RESTART
                    ttg_d    = $signed({1'b0, load_val});
                    reload_d = load_val;
                end else if (tick && reached) begin   // RELOAD
                    expire   = 1'b1;
                    ttg_d    = $signed({1'b0, reload_q});
                end else if (tick) begin              // STEP
                    ttg_d    = ttg_dec;
                end
            end
            default: state_d = CNT_IDLE;
        endcase
    end
endmodule

// File: rtl/done_flag_fsm.sv
module done_flag_fsm
    import ms_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic done
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_LOW:  if (set) state_d = FLAG_HIGH;            // RAISE
            FLAG_HIGH: if (clr && !set) state_d = FLAG_LOW;     // DROP
            default:   state_d = FLAG_LOW;
        endcase
    end

    always_comb begin
        done = (state_q == FLAG_HIGH);
    end
endmodule

// File: rtl/ms_interval_timer.sv
module ms_interval_timer #(
    parameter int WORD_W   = 36,
    parameter int SUB_W    = 12,
    parameter int STAT_BIT = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              per_wr_en,
    input  logic [WORD_W-1:0] per_wr_data,
    input  logic              done_clr,
    output logic [WORD_W-1:0] per_rdata,
    output logic              done_flag,
    output logic              irq,
    output logic [WORD_W-1:0] status_word
);
    logic [WORD_W:0]   rounded;
    logic              is_zero;
    logic              accept;
    logic              expire;
    logic [WORD_W-1:0] period_q;

    period_round #(.WORD_W(WORD_W), .SUB_W(SUB_W)) u_round (
        .raw     (per_wr_data),
        .rounded (rounded),
        .is_zero (is_zero)
    );

    assign accept = per_wr_en && !is_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      period_q <= '0;
        else if (accept) period_q <= per_wr_data;
    end

    ttg_counter #(.WORD_W(WORD_W), .SUB_W(SUB_W)) u_ttg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (rounded),
        .tick     (ms_tick),
        .expire   (expire)
    );

    done_flag_fsm u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (expire),
        .clr   (done_clr),
        .done  (done_flag)
    );

    always_comb begin
        per_rdata             = period_q;
        irq                   = done_flag;
        status_word           = '0;
        status_word[STAT_BIT] = done_flag;
    end
endmodule

// File: rtl/ms_interval_timer_chk.sv
module ms_interval_timer_chk #(
    parameter int WORD_W   = 36,
    parameter int STAT_BIT = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ms_tick,
    input logic              per_wr_en,
    input logic [WORD_W-1:0] per_wr_data,
    input logic              done_clr,
    input logic [WORD_W-1:0] per_rdata,
    input logic              done_flag,
    input logic              irq,
    input logic [WORD_W-1:0] status_word
);
    p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !per_wr_en |=> $stable(per_rdata));

    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (per_wr_en && per_wr_data != '0) |=> (per_rdata == $past(per_wr_data)));

    p_zero_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (per_wr_en && per_wr_data == '0) |=> $stable(per_rdata));

    p_rise_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_tick && !done_flag) |=> !done_flag);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !done_clr) |=> done_flag);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && done_clr && !ms_tick) |=> !done_flag);

    p_write_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (per_wr_en && per_wr_data != '0 && !done_flag) |=> !done_flag);

    p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[STAT_BIT] == irq) && ($countones(status_word) == (irq ? 1 : 0)));
endmodule

bind ms_interval_timer ms_interval_timer_chk #(.WORD_W(WORD_W), .STAT_BIT(STAT_BIT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ms_tick     (ms_tick),
    .per_wr_en   (per_wr_en),
    .per_wr_data (per_wr_data),
    .done_clr    (done_clr),
    .per_rdata   (per_rdata),
    .done_flag   (done_flag),
    .irq         (irq),
    .status_word (status_word)
);

// File: tb/ms_interval_timer_bench.sv
module ms_interval_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic        per_wr_en = 1'b0;
    logic [35:0] per_wr_data = '0;
    logic        done_clr = 1'b0;
    logic [35:0] per_rdata;
    logic        done_flag;
    logic        irq;
    logic [35:0] status_word;

    int unsigned vectors = 0;
    int unsigned fails = 0;
    bit          finished = 1'b0;

    // Reference model state
    logic [35:0] m_period = '0;
    longint      m_ms = 0;
    longint      m_rem = 0;
    bit          m_armed = 1'b0;
    bit          m_done = 1'b0;

    always #5 clk = ~clk;

    ms_interval_timer u_ms_interval_timer (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .per_wr_en(per_wr_en),
        .per_wr_data(per_wr_data), .done_clr(done_clr), .per_rdata(per_rdata),
        .done_flag(done_flag), .irq(irq), .status_word(status_word)
    );

    function automatic longint ms_of(input logic [35:0] p);
        longint n;
        n = longint'(p >> 12);
        if (p[11:0] != 12'd0) n = n + 1;
        return n;
    endfunction

    function automatic logic [35:0] exp_status(input bit d);
        logic [35:0] s;
        s = '0;
        s[30] = d;
        return s;
    endfunction

    task automatic check(input string tag);
        vectors++;
        if (per_rdata !== m_period) begin
            fails++;
            $display("FAIL %s per_rdata actual=%h expected=%h", tag, per_rdata, m_period);
        end
        if (done_flag !== m_done) begin
            fails++;
            $display("FAIL %s done_flag actual=%0b expected=%0b", tag, done_flag, m_done);
        end
        if (irq !== m_done) begin
            fails++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, m_done);
        end
        if (status_word !== exp_status(m_done)) begin
            fails++;
            $display("FAIL %s status_word actual=%h expected=%h", tag, status_word, exp_status(m_done));
        end
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit tk, input bit wr, input logic [35:0] d,
                        input bit cl, input string tag);
        bit set;
        ms_tick = tk; per_wr_en = wr; per_wr_data = d; done_clr = cl;
        @(posedge clk);
        set = 1'b0;
        if (wr && ms_of(d) != 0) begin
            m_period = d; m_ms = ms_of(d); m_rem = m_ms; m_armed = 1'b1;
        end else if (tk && m_armed) begin
            m_rem = m_rem - 1;
            if (m_rem <= 0) begin set = 1'b1; m_rem = m_ms; end
        end
        if (set) m_done = 1'b1;
        else if (cl) m_done = 1'b0;
        @(negedge clk);
        ms_tick = 1'b0; per_wr_en = 1'b0; done_clr = 1'b0;
        check(tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check("R10");                       // outputs during reset
        rst_n = 1'b1;
        @(negedge clk);
        check("R10");

        // R5: strobes before any write do nothing
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, '0, 1'b0, "R5");
        // R3: zero write ignored
        step(1'b0, 1'b1, 36'd0, 1'b0, "R3");
        step(1'b1, 1'b0, '0, 1'b0, "R3");
        // R4: period 1 rounds to 1 ms, expires on very next strobe
        step(1'b0, 1'b1, 36'd1, 1'b0, "R1");
        step(1'b0, 1'b0, '0, 1'b0, "R4");
        step(1'b1, 1'b0, '0, 1'b0, "R4");
        // R6: sticky, then clear coinciding with expiry keeps it
        step(1'b0, 1'b0, '0, 1'b0, "R6");
        step(1'b1, 1'b1 ^ 1'b1, '0, 1'b1, "R6");
        step(1'b0, 1'b0, '0, 1'b1, "R6");
        // R2/R7: 8193 rounds to 3 ms, repeats
        step(1'b0, 1'b1, 36'd8193, 1'b0, "R2");
        for (int k = 0; k < 9; k++) step(1'b1, 1'b0, '0, (k % 3) == 2, "R7");
        // R2: exact multiple 4096*2
        step(1'b0, 1'b1, 36'd8192, 1'b1, "R2");
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, '0, 1'b0, "R2");
        // R3: zero write mid countdown keeps countdown
        step(1'b0, 1'b1, 36'd4096 * 3, 1'b1, "R9");
        step(1'b1, 1'b0, '0, 1'b0, "R3");
        step(1'b0, 1'b1, 36'd0, 1'b0, "R3");
        step(1'b1, 1'b0, '0, 1'b0, "R3");
        step(1'b1, 1'b0, '0, 1'b0, "R3");
        // R9: write with tick in same cycle, no decrement
        step(1'b1, 1'b1, 36'd4096, 1'b1, "R9");
        step(1'b1, 1'b0, '0, 1'b0, "R9");
        // R1: full-width values read back
        step(1'b0, 1'b1, 36'hF_FFFF_FFFF, 1'b1, "R1");
        step(1'b1, 1'b0, '0, 1'b0, "R1");
        step(1'b0, 1'b1, 36'h8_0000_0FFF, 1'b0, "R1");
        step(1'b0, 1'b1, 36'h0_0000_1000, 1'b0, "R8");

        // Constrained random mix
        for (int n = 0; n < 4000; n++) begin
            bit tk, wr, cl;
            logic [35:0] d;
            tk = ($urandom % 3) == 0;
            wr = ($urandom % 40) == 0;
            cl = ($urandom % 6) == 0;
            case ($urandom % 4)
                0:       d = 36'd0;
                1:       d = 36'($urandom % 4096);
                default: d = 36'($urandom % (4096 * 6));
            endcase
            step(tk, wr, d, cl, "R7");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule